// File: doc/BRIEF.md
# Packed SIMD Saturating Adder

This block performs lane-parallel arithmetic on two 32-bit packed operands. A format select splits each operand into four 8-bit lanes or two 16-bit lanes, and every lane is computed on its own with no carry between lanes. The block adds, subtracts, does halving add and subtract with optional round-half-up, and takes the absolute value. For add and subtract the lanes are read as signed or unsigned, and the result either clamps to the lane limits or wraps.

The arithmetic path is purely combinational: `result` and the per-operation overflow indication `ovf_now` follow the inputs in the same cycle. A small registered control field records overflow. When `op_valid` is high and the current operation overflowed, the overflow bit at position 4 of `ovf_field` is set on the next clock edge. It stays set until a control write loads it. The surrounding pipeline reads this field as part of its control register.

Top module: `psimd_sat_alu`

## Requirements
- R1: With `wide_lanes`=0 the operands are four 8-bit lanes; with `wide_lanes`=1 they are two 16-bit lanes. Lane 0 sits in the least significant bits, and no carry or borrow crosses a lane boundary.
- R2: Op code 0 adds and op code 1 subtracts (a minus b) lane by lane, using the full-precision lane values. If `saturate`=1, a result above the lane maximum becomes the maximum and one below the lane minimum becomes the minimum. The limits are signed when `is_signed`=1 and unsigned otherwise, and any clamp raises `ovf_now`.
- R3: If `saturate`=0, add and subtract return the low lane bits of the full-precision result, and `ovf_now` is still raised when that result lies outside the lane range.
- R4: Op code 2 (halving add) and op code 3 (halving subtract) return the full-precision sum or difference shifted right by one. The shift is arithmetic when `is_signed`=1. When `round_up`=1, 1 is added before the shift. Only the low lane bits are kept.
- R5: Op code 4 (absolute value) always reads lanes as signed and ignores `is_signed` and `saturate`. The most negative lane value gives the most positive value and raises `ovf_now`. Any other negative lane is negated, and other lanes pass through unchanged.
- R6: Halving ops never raise `ovf_now`. Op codes 5 to 7 are reserved: they give a zero result and never raise `ovf_now`.
- R7: If `op_valid`=1 and `ovf_now`=1 at a rising clock edge, bit 4 of `ovf_field` reads 1 after that edge.
- R8: Once set, bit 4 of `ovf_field` stays set until a control write. An overflowing operation with `op_valid`=0 does not set it.
- R9: When `ctl_wr`=1 at a clock edge, bit 4 of `ovf_field` is loaded from `ctl_wdata[4]`, and this takes priority over a set in the same cycle. All other bits of `ovf_field` always read 0.
- R10: While `rst_n`=0, `ovf_field` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the overflow field |
| rst_n | input | 1 | Active-low reset |
| op_valid | input | 1 | Current operation commits its overflow indication |
| op | input | 3 | Operation code (0 add, 1 sub, 2 halving add, 3 halving sub, 4 abs, 5-7 reserved) |
| wide_lanes | input | 1 | 0: four 8-bit lanes, 1: two 16-bit lanes |
| is_signed | input | 1 | Read lanes as signed for add, sub and halving ops |
| saturate | input | 1 | Clamp add/sub results instead of wrapping |
| round_up | input | 1 | Add one before the halving shift |
| opa | input | 32 | First packed operand |
| opb | input | 32 | Second packed operand |
| ctl_wr | input | 1 | Control write to the overflow field |
| ctl_wdata | input | 8 | Control write data; bit 4 is the overflow bit |
| result | output | 32 | Packed lane results |
| ovf_now | output | 1 | Some lane of the current operation overflowed |
| ovf_field | output | 8 | Control field with the sticky overflow bit at position 4 |

## Verification
The bench builds the block with its default lane widths of 8 and 16 bits. This keeps the sweep over operand bytes small enough to visit every op code, format, signedness, saturate and rounding setting. The byte list includes 0x00, 0x01, 0x7E, 0x7F, 0x80, 0x81, 0xFE and 0xFF. The bytes are packed so that the 16-bit lanes also reach 0x8000, 0x7FFF and their neighbours, which brings the clamp, wrap and abs-of-minimum corners of both formats within reach. Clocked sequences then check the sticky bit: setting, holding, write priority and reset.

// File: rtl/psimd_pkg.sv
package psimd_pkg;
  localparam logic [2:0] OPC_ADD  = 3'd0;
  localparam logic [2:0] OPC_SUB  = 3'd1;
  localparam logic [2:0] OPC_HADD = 3'd2;
  localparam logic [2:0] OPC_HSUB = 3'd3;
  localparam logic [2:0] OPC_ABS  = 3'd4;

  function automatic logic is_halving(input logic [2:0] opc);
    return (opc == OPC_HADD) || (opc == OPC_HSUB);
  endfunction

  function automatic logic is_adding(input logic [2:0] opc);
    return (opc == OPC_ADD) || (opc == OPC_HADD);
  endfunction
endpackage

// File: rtl/psimd_lane.sv
module psimd_lane
  import psimd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   op,
  input  logic         sgn,
  input  logic         sat,
  input  logic         rnd,
  output logic [W-1:0] y,
  output logic         ovf
);
  localparam int XW = W + 2;
  localparam logic signed [XW-1:0] SMAX = XW'((1 << (W - 1)) - 1);
  localparam logic signed [XW-1:0] SMIN = -SMAX - XW'(1);
  localparam logic signed [XW-1:0] UMAX = XW'((1 << W) - 1);
  localparam logic signed [XW-1:0] UMIN = '0;
  localparam logic [W-1:0] LANE_MIN = {1'b1, {(W-1){1'b0}}};

  function automatic logic signed [XW-1:0] widen(input logic [W-1:0] v, input logic s);
    return s ? {{2{v[W-1]}}, v} : {2'b00, v};
  endfunction

  logic signed [XW-1:0] ax, bx, full, hsum, hi, lo;
  logic                 above, below;
  logic [W-1:0]         clamp_y, half_y, abs_y;
  logic                 abs_ovf;

  always_comb begin
    ax    = widen(a, sgn);
    bx    = widen(b, sgn);
    full  = is_adding(op) ? (ax + bx) : (ax - bx);
    hi    = sgn ? SMAX : UMAX;
    lo    = sgn ? SMIN : UMIN;
    above = full > hi;
    below = full < lo;
    if (sat && above)      clamp_y = hi[W-1:0];
    else if (sat && below) clamp_y = lo[W-1:0];
    else                   clamp_y = full[W-1:0];
    hsum   = full + (rnd ? XW'(1) : XW'(0));
    half_y = hsum[W:1];
    abs_ovf = (a == LANE_MIN);
    if (abs_ovf)     abs_y = SMAX[W-1:0];
    else if (a[W-1]) abs_y = (~a) + W'(1);
    else             abs_y = a;
  end

  always_comb begin
    y   = '0;
    ovf = 1'b0;
    case (op)
      OPC_ADD, OPC_SUB: begin
        y   = clamp_y;
        ovf = above || below;
      end
      OPC_HADD, OPC_HSUB: y = half_y;
      OPC_ABS: begin
        y   = abs_y;
        ovf = abs_ovf;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/psimd_lane_array.sv
module psimd_lane_array #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [2:0]        op,
  input  logic              sgn,
  input  logic              sat,
  input  logic              rnd,
  output logic [DATA_W-1:0] y,
  output logic              any_ovf
);
  localparam int NL = DATA_W / LANE_W;
  logic [NL-1:0] lane_ovf;

  for (genvar k = 0; k < NL; k++) begin : g_lane
    psimd_lane #(.W(LANE_W)) i_lane (
      .a   (a[k*LANE_W +: LANE_W]),
      .b   (b[k*LANE_W +: LANE_W]),
      .op  (op),
      .sgn (sgn),
      .sat (sat),
      .rnd (rnd),
      .y   (y[k*LANE_W +: LANE_W]),
      .ovf (lane_ovf[k])
    );
  end

  assign any_ovf = |lane_ovf;
endmodule

// File: rtl/psimd_sticky.sv
module psimd_sticky #(
  parameter int FIELD_W = 8,
  parameter int OVF_POS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set,
  input  logic               wr,
  input  logic               wbit,
  output logic [FIELD_W-1:0] field
);
  logic flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (wr)  flag <= wbit;
    else if (set) flag <= 1'b1;
  end

  always_comb begin
    field          = '0;
    field[OVF_POS] = flag;
  end

  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    field[OVF_POS] && !wr |=> field[OVF_POS]);
  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> field[OVF_POS] == $past(wbit));
  p_quiet_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !field[OVF_POS] && !wr && !set |=> !field[OVF_POS]);
endmodule

// File: rtl/psimd_sat_alu.sv
module psimd_sat_alu
  import psimd_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 16,
  parameter int FIELD_W  = 8,
  parameter int OVF_POS  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [2:0]         op,
  input  logic               wide_lanes,
  input  logic               is_signed,
  input  logic               saturate,
  input  logic               round_up,
  input  logic [DATA_W-1:0]  opa,
  input  logic [DATA_W-1:0]  opb,
  input  logic               ctl_wr,
  input  logic [FIELD_W-1:0] ctl_wdata,
  output logic [DATA_W-1:0]  result,
  output logic               ovf_now,
  output logic [FIELD_W-1:0] ovf_field
);
  logic [DATA_W-1:0] narrow_y, wide_y;
  logic              narrow_ovf, wide_ovf;
  logic              commit_ovf;
  logic              abs_signed;

  // abs always reads lanes as signed
  assign abs_signed = (op == OPC_ABS) ? 1'b1 : is_signed;

  psimd_lane_array #(.DATA_W(DATA_W), .LANE_W(NARROW_W)) i_narrow (
    .a(opa), .b(opb), .op(op), .sgn(abs_signed), .sat(saturate), .rnd(round_up),
    .y(narrow_y), .any_ovf(narrow_ovf)
  );

  psimd_lane_array #(.DATA_W(DATA_W), .LANE_W(WIDE_W)) i_wide (
    .a(opa), .b(opb), .op(op), .sgn(abs_signed), .sat(saturate), .rnd(round_up),
    .y(wide_y), .any_ovf(wide_ovf)
  );

  assign result     = wide_lanes ? wide_y : narrow_y;
  assign ovf_now    = wide_lanes ? wide_ovf : narrow_ovf;
  assign commit_ovf = op_valid && ovf_now;

  psimd_sticky #(.FIELD_W(FIELD_W), .OVF_POS(OVF_POS)) i_sticky (
    .clk(clk), .rst_n(rst_n), .set(commit_ovf), .wr(ctl_wr),
    .wbit(ctl_wdata[OVF_POS]), .field(ovf_field)
  );

  p_halving_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_halving(op) |-> !ovf_now);
  p_set_on_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && ovf_now && !ctl_wr |=> ovf_field[OVF_POS]);
  p_abs_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OPC_ABS) && !wide_lanes &&
    (opa[NARROW_W-1:0] == {1'b1, {(NARROW_W-1){1'b0}}})
    |-> (result[NARROW_W-1:0] == {1'b0, {(NARROW_W-1){1'b1}}}) && ovf_now);
  p_field_others_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ovf_field) <= 1);
endmodule

// File: tb/test_psimd_sat_alu.sv
module test_psimd_sat_alu;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        wide_lanes = 1'b0, is_signed = 1'b0, saturate = 1'b0, round_up = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [31:0] result;
  logic        ovf_now;
  logic [7:0]  ovf_field;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  psimd_sat_alu i_psimd_sat_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .wide_lanes(wide_lanes),
    .is_signed(is_signed), .saturate(saturate), .round_up(round_up), .opa(opa), .opb(opb),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .result(result), .ovf_now(ovf_now),
    .ovf_field(ovf_field)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lane_model(input int opc, input int w, input bit sg, input bit st,
                                    input bit rd, input int ua, input int ub, output bit ov);
    int full = 1 << w;
    int half = 1 << (w - 1);
    bit s = (opc == 4) ? 1'b1 : sg;
    int va = (s && ua >= half) ? ua - full : ua;
    int vb = (s && ub >= half) ? ub - full : ub;
    int mx = s ? half - 1 : full - 1;
    int mn = s ? -half : 0;
    int r = 0;
    ov = 0;
    case (opc)
      0, 1: begin
        r = (opc == 0) ? va + vb : va - vb;
        ov = (r > mx) || (r < mn);
        if (st && r > mx) r = mx;
        else if (st && r < mn) r = mn;
      end
      2, 3: begin
        r = (opc == 2) ? va + vb : va - vb;
        if (rd) r = r + 1;
        r = r >>> 1;
      end
      4: begin
        if (va == -half) begin r = half - 1; ov = 1; end
        else r = (va < 0) ? -va : va;
      end
      default: r = 0;
    endcase
    return r & (full - 1);
  endfunction

  task automatic model(input int opc, input bit wd, input bit sg, input bit st, input bit rd,
                       input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] y, output bit ov);
    int w = wd ? 16 : 8;
    int m = (1 << w) - 1;
    y = '0;
    ov = 0;
    for (int k = 0; k < 32 / w; k++) begin
      bit lov;
      int r = lane_model(opc, w, sg, st, rd, int'(a >> (k * w)) & m, int'(b >> (k * w)) & m, lov);
      y = y | (32'(r) << (k * w));
      ov = ov | lov;
    end
  endtask

  function automatic logic [7:0] pick(input int i);
    case (i)
      0: return 8'h00;
      1: return 8'h01;
      2: return 8'h7E;
      3: return 8'h7F;
      4: return 8'h80;
      5: return 8'h81;
      6: return 8'hFE;
      7: return 8'hFF;
      default: return 8'((i * 53) & 255);
    endcase
  endfunction

  function automatic string tag_of(input int opc, input bit st);
    if (opc <= 1) return st ? "R2" : "R3";
    if (opc <= 3) return "R4";
    if (opc == 4) return "R5";
    return "R6";
  endfunction

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] ey;
    bit eo;
    // R10: reset clears the field
    repeat (3) @(negedge clk);
    chk(ovf_field == 8'h00, "R10 reset field", {24'h0, ovf_field}, 32'h0);
    rst_n = 1'b1;

    // R1: no carry across 8-bit lanes in wrap mode
    op = 3'd0; wide_lanes = 0; is_signed = 0; saturate = 0;
    opa = 32'h00FF00FF; opb = 32'h00010001; #1;
    chk(result == 32'h00000000, "R1 narrow lane isolation", result, 32'h0);
    wide_lanes = 1; #1;
    chk(result == 32'h01000100, "R1 wide lane isolation", result, 32'h01000100);
    opa = 32'h00000001; opb = 32'h00000002; op = 3'd1; wide_lanes = 0; #1;
    chk(result == 32'h000000FF, "R1 lane 0 in low bits", result, 32'h000000FF);

    // Sweep: all ops, formats and modes over a byte list (R1-R6)
    for (int wd = 0; wd < 2; wd++)
      for (int opc = 0; opc < 8; opc++)
        for (int m = 0; m < 8; m++)
          for (int i = 0; i < 40; i++)
            for (int j = 0; j < 40; j++) begin
              logic [7:0] va = pick(i);
              logic [7:0] vb = pick(j);
              wide_lanes = wd[0]; op = 3'(opc);
              is_signed = m[0]; saturate = m[1]; round_up = m[2];
              opa = {va, ~va, va, va ^ 8'h80};
              opb = {vb ^ 8'hFF, vb, vb ^ 8'h80, vb};
              #1;
              model(opc, wd[0], m[0], m[1], m[2], opa, opb, ey, eo);
              chk(result == ey, tag_of(opc, m[1]), result, ey);
              chk(ovf_now == eo, {tag_of(opc, m[1]), " ovf"}, {31'h0, ovf_now}, {31'h0, eo});
            end

    // R8: overflow with op_valid low does not set
    @(negedge clk);
    op = 3'd0; wide_lanes = 0; is_signed = 1; saturate = 1; round_up = 0;
    opa = 32'h0000007F; opb = 32'h00000001; op_valid = 0;
    @(negedge clk);
    chk(ovf_field == 8'h00, "R8 no set without op_valid", {24'h0, ovf_field}, 32'h0);
    // R7: set on next edge
    op_valid = 1;
    @(negedge clk);
    chk(ovf_field == 8'h10, "R7 set after overflow", {24'h0, ovf_field}, 32'h10);
    // R8: holds
    op_valid = 0; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    chk(ovf_field == 8'h10, "R8 sticky hold", {24'h0, ovf_field}, 32'h10);
    op_valid = 1;
    @(negedge clk);
    chk(ovf_field == 8'h10, "R8 hold under clean op", {24'h0, ovf_field}, 32'h10);
    op_valid = 0;
    // R9: clear by write
    ctl_wr = 1; ctl_wdata = 8'h00;
    @(negedge clk);
    ctl_wr = 0;
    chk(ovf_field == 8'h00, "R9 clear by write", {24'h0, ovf_field}, 32'h0);
    // R6: halving op never sets
    op = 3'd2; is_signed = 0; opa = 32'hFFFFFFFF; opb = 32'hFFFFFFFF; op_valid = 1;
    @(negedge clk);
    chk(ovf_field == 8'h00, "R6 halving no set", {24'h0, ovf_field}, 32'h0);
    // R6: reserved op gives zero and never sets
    op = 3'd6; saturate = 0;
    @(negedge clk);
    chk(result == 32'h0, "R6 reserved result", result, 32'h0);
    chk(ovf_field == 8'h00, "R6 reserved no set", {24'h0, ovf_field}, 32'h0);
    // R9: write priority over set
    op = 3'd0; is_signed = 1; opa = 32'h0000007F; opb = 32'h00000001;
    ctl_wr = 1; ctl_wdata = 8'hEF;
    @(negedge clk);
    chk(ovf_field == 8'h00, "R9 write beats set", {24'h0, ovf_field}, 32'h0);
    op_valid = 0; ctl_wdata = 8'hFF;
    @(negedge clk);
    ctl_wr = 0;
    chk(ovf_field == 8'h10, "R9 only bit 4 held", {24'h0, ovf_field}, 32'h10);
    ctl_wr = 1; ctl_wdata = 8'h00;
    @(negedge clk);
    ctl_wr = 0;
    // R5/R7: abs of the minimum sets the bit
    op = 3'd4; wide_lanes = 1; opa = 32'h00008000; op_valid = 1; #1;
    chk(result == 32'h00007FFF, "R5 abs of wide minimum", result, 32'h00007FFF);
    @(negedge clk);
    op_valid = 0;
    chk(ovf_field == 8'h10, "R7 abs overflow sets", {24'h0, ovf_field}, 32'h10);
    // R10: reset clears again
    rst_n = 0;
    @(negedge clk);
    chk(ovf_field == 8'h00, "R10 reset clears set bit", {24'h0, ovf_field}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule